// File: doc/BRIEF.md
# JTAG-Gated Trace Client Enable

This block decides whether an on-chip debug and trace client may run. A 16-state TAP controller clocked by `tck` decodes the test port. It drives a 4-bit instruction register. Behind one auxiliary-access opcode sits a 10-bit emulation command register. The client is switched on only after the instruction register holds that opcode and a scan of the command register then writes the client-access code `10'h07C`.

The enable is lost on every reset path:
- Test-Logic-Reset reached through TMS.
- The asynchronous TAP reset input.
- Power-on reset.

While the client is off, the block forces the auxiliary trace pins to their idle levels. It also refuses register traffic from the debug host. Reads return zero and writes are not passed on.

Top module: `dbg_trace_gate`

## Requirements
- R1: The TAP follows the standard 16-state graph on each rising `tck` edge. Five consecutive edges with `tms` high reach Test-Logic-Reset from any state.
- R2: The instruction register is 4 bits wide and shifts LSB first from `tdi`. It loads 4'b0001 in Capture-IR and is reset to all ones (bypass) in Test-Logic-Reset. During Shift-IR, `tdo` shows its bit 0.
- R3: While the instruction is the auxiliary opcode (default 4'b0001), a 10-bit command register sits on the data path. Capture-DR loads its current value. Shift-DR shifts it LSB first from `tdi`, with `tdo` showing bit 0. Update-DR stores it.
- R4: `client_en` rises on the edge that leaves Update-DR, but only if the instruction is the auxiliary opcode and the shifted command equals 10'b00_0111_1100.
- R5: Any other command value does not set `client_en`. Once set, `client_en` stays set across later instruction loads and command loads until a reset path occurs.
- R6: Entering Test-Logic-Reset through TMS clears `client_en` on the same edge.
- R7: `trst_n` low asynchronously forces Test-Logic-Reset and clears `client_en`.
- R8: `por_n` low asynchronously forces Test-Logic-Reset and clears `client_en` and the command register.
- R9: While disabled, the trace pins are held idle: `aux_data`=0, `aux_se`=2'b11, `aux_clk`=0 and `aux_oe`=0. While enabled, `aux_oe`=1 and the trace inputs pass through.
- R10: While disabled, `rd_data` is 0 and `cli_rd`/`cli_wr` are low. While enabled, the client read data and the requests pass through.
- R11: Any opcode other than the auxiliary one selects a 1-bit bypass register, which Capture-DR clears. In Shift-DR, `tdo` shows `tdi` from the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| trst_n | input | 1 | TAP reset, active low, asynchronous |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| tdo | output | 1 | Test data out |
| client_en | output | 1 | Trace client enabled |
| tr_data | input | MDO_W | Trace message data from the client |
| tr_se | input | 2 | Message start/end from the client |
| tr_clk | input | 1 | Message clock from the client |
| aux_data | output | MDO_W | Gated message data pins |
| aux_se | output | 2 | Gated message start/end pins |
| aux_clk | output | 1 | Gated message clock pin |
| aux_oe | output | 1 | Output enable for the auxiliary pins |
| rd_req | input | 1 | Host read request |
| wr_req | input | 1 | Host write request |
| cli_rdata | input | REG_W | Read data from client registers |
| rd_data | output | REG_W | Read data to the host |
| cli_rd | output | 1 | Read strobe passed to the client |
| cli_wr | output | 1 | Write strobe passed to the client |

## Verification
The enable timing follows from the state register. `client_en` changes on the same `tck` edge that leaves Update-DR or enters Test-Logic-Reset. The pin gating and the register gating follow `client_en` with no added delay. `tdo` reflects the register that was loaded or shifted on the preceding edge. The asynchronous resets act with no clock at all. The bench drives `tms`/`tdi` on the falling edge. It steps a behavioural model on the rising edge and compares every output 5 ns after each rising edge, so each result is sampled in the cycle it is due. Directed checks read back the captured scan bits and the enable after each scan phase.

// File: rtl/dbg_trace_gate.sv
module dbg_trace_gate #(
  parameter int          IR_W       = 4,
  parameter int          CMD_W      = 10,
  parameter logic [3:0]  AUX_OP     = 4'b0001,
  parameter logic [9:0]  CLIENT_CMD = 10'b00_0111_1100,
  parameter int          MDO_W      = 8,
  parameter int          REG_W      = 32
) (
  input  logic             tck,
  input  logic             por_n,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             client_en,
  input  logic [MDO_W-1:0] tr_data,
  input  logic [1:0]       tr_se,
  input  logic             tr_clk,
  output logic [MDO_W-1:0] aux_data,
  output logic [1:0]       aux_se,
  output logic             aux_clk,
  output logic             aux_oe,
  input  logic             rd_req,
  input  logic             wr_req,
  input  logic [REG_W-1:0] cli_rdata,
  output logic [REG_W-1:0] rd_data,
  output logic             cli_rd,
  output logic             cli_wr
);
  localparam logic [IR_W-1:0] IR_CAPT = IR_W'(1);
  localparam logic [IR_W-1:0] IR_BYP  = '1;

  typedef enum logic [3:0] {
    TLR = 4'd0, RTI = 4'd1, SDS = 4'd2, CDR = 4'd3,
    SDR = 4'd4, E1D = 4'd5, PDR = 4'd6, E2D = 4'd7,
    UDR = 4'd8, SIS = 4'd9, CIR = 4'd10, SIR = 4'd11,
    E1I = 4'd12, PIR = 4'd13, E2I = 4'd14, UIR = 4'd15
  } tap_t;

  tap_t             st, nx;
  logic [IR_W-1:0]  ir_sr, ir;
  logic [CMD_W-1:0] cmd_sr, cmd;
  logic             byp, en;

  wire rst_n  = por_n & trst_n;
  wire aux_on = (ir == AUX_OP);

  always_comb begin
    case (st)
      TLR:     nx = tms ? TLR : RTI;
      RTI:     nx = tms ? SDS : RTI;
      SDS:     nx = tms ? SIS : CDR;
      CDR:     nx = tms ? E1D : SDR;
      SDR:     nx = tms ? E1D : SDR;
      E1D:     nx = tms ? UDR : PDR;
      PDR:     nx = tms ? E2D : PDR;
      E2D:     nx = tms ? UDR : SDR;
      UDR:     nx = tms ? SDS : RTI;
      SIS:     nx = tms ? TLR : CIR;
      CIR:     nx = tms ? E1I : SIR;
      SIR:     nx = tms ? E1I : SIR;
      E1I:     nx = tms ? UIR : PIR;
      PIR:     nx = tms ? E2I : PIR;
      E2I:     nx = tms ? UIR : SIR;
      default: nx = tms ? SDS : RTI;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      st    <= TLR;
      ir_sr <= IR_CAPT;
      ir    <= IR_BYP;
      byp   <= 1'b0;
      en    <= 1'b0;
    end else begin
      st <= nx;
      case (st)
        TLR: ir    <= IR_BYP;
        CIR: ir_sr <= IR_CAPT;
        SIR: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        UIR: ir    <= ir_sr;
        CDR: if (!aux_on) byp <= 1'b0;
        SDR: if (!aux_on) byp <= tdi;
        UDR: if (aux_on && cmd_sr == CLIENT_CMD) en <= 1'b1;
        default: ;
      endcase
      if (nx == TLR) en <= 1'b0;
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      cmd_sr <= '0;
      cmd    <= '0;
    end else if (aux_on) begin
      case (st)
        CDR: cmd_sr <= cmd;
        SDR: cmd_sr <= {tdi, cmd_sr[CMD_W-1:1]};
        UDR: cmd    <= cmd_sr;
        default: ;
      endcase
    end
  end

  always_comb begin
    tdo = 1'b0;
    if (st == SIR)      tdo = ir_sr[0];
    else if (st == SDR) tdo = aux_on ? cmd_sr[0] : byp;
  end

  assign client_en = en;
  assign aux_oe    = en;
  assign aux_data  = en ? tr_data : '0;
  assign aux_se    = en ? tr_se   : 2'b11;
  assign aux_clk   = en & tr_clk;
  assign rd_data   = en ? cli_rdata : '0;
  assign cli_rd    = en & rd_req;
  assign cli_wr    = en & wr_req;
endmodule

// File: rtl/dbg_trace_gate_chk.sv
module dbg_trace_gate_chk #(
  parameter int REG_W = 32
) (
  input logic             tck,
  input logic             por_n,
  input logic             trst_n,
  input logic             tms,
  input logic [3:0]       st,
  input logic [3:0]       ir_sr,
  input logic [3:0]       ir,
  input logic [9:0]       cmd_sr,
  input logic             client_en,
  input logic             aux_oe,
  input logic [1:0]       aux_se,
  input logic [REG_W-1:0] rd_data,
  input logic             cli_wr
);
  logic [2:0] hi_run;
  always_ff @(posedge tck or negedge por_n or negedge trst_n) begin
    if (!por_n || !trst_n) hi_run <= '0;
    else if (!tms)         hi_run <= '0;
    else if (hi_run != 3'd5) hi_run <= hi_run + 3'd1;
  end

  assert_five_tms_R6: assert property (@(posedge tck) disable iff (!por_n || !trst_n)
    (hi_run == 3'd5) |-> (st == 4'd0 && !client_en));

  assert_capture_ir_R2: assert property (@(posedge tck) disable iff (!por_n || !trst_n)
    (st == 4'd10) |=> (ir_sr == 4'b0001));

  assert_enable_source_R4: assert property (@(posedge tck) disable iff (!por_n || !trst_n)
    $rose(client_en) |-> ($past(st) == 4'd8 && $past(cmd_sr) == 10'h07C && $past(ir) == 4'b0001));

  assert_enable_holds_R5: assert property (@(posedge tck) disable iff (!por_n || !trst_n)
    (client_en && !tms) |=> client_en);

  assert_trst_clears_R7: assert property (@(posedge tck) disable iff (!por_n)
    (!trst_n) |-> !client_en);

  assert_pins_idle_R9: assert property (@(posedge tck) disable iff (!por_n)
    (!client_en) |-> (!aux_oe && aux_se == 2'b11));

  assert_reg_blocked_R10: assert property (@(posedge tck) disable iff (!por_n)
    (cli_wr || rd_data != '0) |-> client_en);
endmodule

bind dbg_trace_gate dbg_trace_gate_chk #(.REG_W(REG_W)) u_chk (
  .tck(tck), .por_n(por_n), .trst_n(trst_n), .tms(tms), .st(st),
  .ir_sr(ir_sr), .ir(ir), .cmd_sr(cmd_sr), .client_en(client_en),
  .aux_oe(aux_oe), .aux_se(aux_se), .rd_data(rd_data), .cli_wr(cli_wr)
);

// File: tb/dbg_trace_gate_test.sv
`timescale 1ns/1ps
module dbg_trace_gate_test;
  localparam int MW = 8;
  localparam int RW = 32;

  logic tck = 0, por_n = 0, trst_n = 1, tms = 1, tdi = 0;
  logic tdo, client_en, aux_clk, aux_oe, cli_rd, cli_wr;
  logic [MW-1:0] tr_data = 8'hA5, aux_data;
  logic [1:0] tr_se = 2'b01, aux_se;
  logic tr_clk = 1, rd_req = 1, wr_req = 1;
  logic [RW-1:0] cli_rdata = 32'h1234_5678, rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 tck = ~tck;

  dbg_trace_gate uut (
    .tck(tck), .por_n(por_n), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .client_en(client_en), .tr_data(tr_data), .tr_se(tr_se), .tr_clk(tr_clk),
    .aux_data(aux_data), .aux_se(aux_se), .aux_clk(aux_clk), .aux_oe(aux_oe),
    .rd_req(rd_req), .wr_req(wr_req), .cli_rdata(cli_rdata), .rd_data(rd_data),
    .cli_rd(cli_rd), .cli_wr(cli_wr));

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: states 0=TLR 1=RTI 2=SelDR 3=CapDR 4=ShDR 5=Ex1DR
  // 6=PauseDR 7=Ex2DR 8=UpdDR 9=SelIR 10=CapIR 11=ShIR 12=Ex1IR 13=PauseIR 14=Ex2IR 15=UpdIR
  function automatic int tap_next(int s, bit t);
    int succ[16][2] = '{'{1,0},'{1,2},'{3,9},'{4,5},'{4,5},'{6,8},'{6,7},'{4,8},
                        '{1,2},'{10,0},'{11,12},'{11,12},'{13,15},'{13,14},'{11,15},'{1,2}};
    return succ[s][t];
  endfunction

  int m_st, m_ir, m_irsh, m_cmd, m_cmdsh, m_byp;
  bit m_en;
  always @(posedge tck or negedge por_n or negedge trst_n) begin
    if (!por_n || !trst_n) begin
      m_st = 0; m_ir = 15; m_irsh = 1; m_byp = 0; m_en = 0;
      if (!por_n) begin m_cmd = 0; m_cmdsh = 0; end
    end else begin
      case (m_st)
        0:  m_ir = 15;
        10: m_irsh = 1;
        11: m_irsh = (m_irsh >> 1) | (int'(tdi) << 3);
        15: m_ir = m_irsh;
        3:  if (m_ir == 1) m_cmdsh = m_cmd; else m_byp = 0;
        4:  if (m_ir == 1) m_cmdsh = (m_cmdsh >> 1) | (int'(tdi) << 9); else m_byp = tdi;
        8:  if (m_ir == 1) begin m_cmd = m_cmdsh; if (m_cmdsh == 'h07C) m_en = 1; end
        default: ;
      endcase
      m_st = tap_next(m_st, tms);
      if (m_st == 0) m_en = 0;
    end
  end

  always @(posedge tck) begin
    #5;
    if (por_n) begin
      bit etdo;
      etdo = (m_st == 11) ? m_irsh[0] : (m_st == 4) ? ((m_ir == 1) ? m_cmdsh[0] : m_byp[0]) : 1'b0;
      chk(client_en == m_en, "R4 model enable", client_en, m_en);
      chk(tdo == etdo, "R2 model tdo", tdo, etdo);
      chk(aux_oe == m_en && aux_data == (m_en ? tr_data : 8'h00) &&
          aux_se == (m_en ? tr_se : 2'b11) && aux_clk == (m_en & tr_clk),
          "R9 model pins", {aux_oe, aux_data, aux_se, aux_clk}, m_en);
      chk(rd_data == (m_en ? cli_rdata : 0) && cli_wr == m_en && cli_rd == m_en,
          "R10 model access", rd_data, m_en ? cli_rdata : 0);
    end
  end

  task automatic step(bit t, bit d);
    tms = t; tdi = d;
    @(posedge tck); @(negedge tck);
  endtask

  task automatic shift_ir(input logic [3:0] v, output logic [3:0] cap);
    step(1,0); step(1,0); step(0,0); step(0,0);
    for (int i = 0; i < 4; i++) begin cap[i] = tdo; step(i == 3, v[i]); end
    step(1,0); step(0,0);
  endtask

  task automatic shift_dr(input logic [9:0] v, output logic [9:0] cap);
    step(1,0); step(0,0); step(0,0);
    for (int i = 0; i < 10; i++) begin cap[i] = tdo; step(i == 9, v[i]); end
    step(1,0); step(0,0);
  endtask

  task automatic enable_client();
    logic [3:0] c4; logic [9:0] c10;
    shift_ir(4'b0001, c4);
    shift_dr(10'h07C, c10);
  endtask

  initial begin
    logic [3:0] c4; logic [9:0] c10;
    @(negedge tck); @(negedge tck);
    chk(client_en == 0, "R8 enable low in power-on reset", client_en, 0);
    chk(aux_oe == 0 && aux_se == 2'b11 && aux_data == 0 && aux_clk == 0, "R9 idle pins in reset", aux_se, 2'b11);
    chk(rd_data == 0 && cli_wr == 0, "R10 access blocked in reset", rd_data, 0);
    por_n = 1;
    step(0,0);

    shift_ir(4'b0001, c4);
    chk(c4 == 4'b0001, "R2 Capture-IR value", c4, 4'b0001);
    shift_dr(10'h07D, c10);
    chk(c10 == 10'h000, "R3 command capture after reset", c10, 0);
    chk(client_en == 0, "R5 wrong command ignored", client_en, 0);
    chk(rd_data == 0 && cli_rd == 0, "R10 read refused while disabled", rd_data, 0);

    shift_dr(10'h07C, c10);
    chk(c10 == 10'h07D, "R3 command readback", c10, 10'h07D);
    chk(client_en == 1, "R4 correct command enables", client_en, 1);
    chk(aux_oe && aux_data == 8'hA5 && aux_se == 2'b01, "R9 pins pass when enabled", aux_data, 8'hA5);
    chk(rd_data == 32'h1234_5678 && cli_wr, "R10 access when enabled", rd_data, 32'h1234_5678);

    shift_dr(10'h155, c10);
    chk(c10 == 10'h07C, "R3 stored command", c10, 10'h07C);
    chk(client_en == 1, "R5 later command keeps enable", client_en, 1);

    shift_ir(4'b1111, c4);
    chk(client_en == 1, "R5 IR change keeps enable", client_en, 1);
    shift_dr(10'h2B3, c10);
    chk(c10 == {10'h2B3 << 1} , "R11 bypass delay", c10, 10'h2B3 << 1);

    step(1,0); step(1,0); step(0,0); step(0,0);
    for (int i = 0; i < 4; i++) step(1,0);
    chk(client_en == 1, "R6 four TMS-high edges not yet reset", client_en, 1);
    step(1,0);
    chk(client_en == 0, "R1 R6 five TMS-high edges reach reset", client_en, 0);
    chk(aux_oe == 0 && aux_se == 2'b11, "R9 pins idle after TMS reset", aux_se, 2'b11);
    step(0,0);
    shift_dr(10'h07C, c10);
    chk(client_en == 0, "R2 IR reset to bypass blocks enable", client_en, 0);

    shift_ir(4'b0010, c4);
    shift_dr(10'h07C, c10);
    chk(client_en == 0, "R4 command needs auxiliary opcode", client_en, 0);

    enable_client();
    chk(client_en == 1, "R4 re-enable", client_en, 1);
    #3 trst_n = 0; #2;
    chk(client_en == 0 && aux_oe == 0, "R7 TAP reset clears enable", client_en, 0);
    @(negedge tck); trst_n = 1; step(0,0);
    shift_dr(10'h000, c10);
    chk(c10 == 10'h000, "R7 bypass selected after TAP reset", c10, 0);

    enable_client();
    chk(client_en == 1, "R4 re-enable before power-on reset", client_en, 1);
    #3 por_n = 0; #2;
    chk(client_en == 0 && rd_data == 0, "R8 power-on reset clears enable", client_en, 0);
    @(negedge tck); por_n = 1; step(0,0);
    shift_ir(4'b0001, c4);
    shift_dr(10'h000, c10);
    chk(c10 == 10'h000, "R8 command cleared by power-on reset", c10, 0);
    tr_data = 8'h3C; tr_se = 2'b10;
    step(0,0);
    chk(aux_data == 0 && aux_se == 2'b11, "R9 new trace input blocked", aux_data, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge tck);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule